// File: doc/BRIEF.md
# Multicast Group Address Hash Filter

The block decides whether a received frame carrying a group destination address is wanted. The six destination address bytes arrive one per valid cycle, first byte flagged. A CRC-32 is run over them bit-serially, least significant bit of each byte first. The top eight bits of the bit-reversed remainder form a hash index into a 256-entry bit table, and the selected table bit gives the accept decision.

The table is held as eight 32-bit words, all cleared at reset so nothing is accepted until software programs it. A write port can set or clear the single entry for a given hash index, or load a whole word. A combinational read port returns any word. Addresses whose group bit is clear bypass the table and are always reported as not accepted.

Top module: `mcast_hash_filter`

## Requirements
- R1: After rst_ni is asserted low, every table word reads as zero on rd_data_o, and result_valid_o and accept_o are low.
- R2: hash_idx_o equals bits 31..24 of the bit-reversed CRC-32 remainder. The CRC uses polynomial 0x04C11DB7 with an all-ones seed and no final inversion. The six bytes are processed in arrival order, each byte least significant bit first. Equivalently, the index is the top eight bits of a left-shifting register fed with those bits.
- R3: result_valid_o is high for exactly one cycle. It rises on the first rising edge after the edge that samples the sixth address byte.
- R4: Hash index bits 7..5 select the table word and bits 4..0 select bit (31 - index[4:0]) of that word. Entry 0 is bit 31 of word 0 and entry 255 is bit 0 of word 7. rd_sel_i picks the word shown on rd_data_o.
- R5: accept_o is high only with result_valid_o. It equals the group bit (bit 0 of the first address byte) ANDed with the addressed table entry. With the group bit clear it is low whatever the table holds.
- R6: sw_op_i = 2'b01 sets the entry at sw_idx_i and leaves every other entry unchanged.
- R7: sw_op_i = 2'b10 clears the entry at sw_idx_i and leaves every other entry unchanged.
- R8: sw_op_i = 2'b11 loads sw_wdata_i into word sw_idx_i[7:5] and leaves the other words unchanged. sw_op_i = 2'b00 does nothing.
- R9: byte_first_i with byte_valid_i restarts the address, dropping any partial one. Valid bytes that arrive without a start, or after the sixth byte, are ignored and produce no result.
- R10: The decision uses the table contents held before the edge that raises result_valid_o. A write on that same edge affects only later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Address byte present |
| byte_first_i | input | 1 | Present byte is the first of an address |
| byte_data_i | input | 8 | Address byte |
| sw_op_i | input | 2 | Table operation: 00 none, 01 set, 10 clear, 11 word write |
| sw_idx_i | input | 8 | Hash index for set or clear; bits 7..5 give the word for a word write |
| sw_wdata_i | input | 32 | Word write data |
| rd_sel_i | input | 3 | Table word to read |
| rd_data_o | output | 32 | Selected table word |
| result_valid_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted by the filter |
| is_group_o | output | 1 | Group bit of the last address |
| hash_idx_o | output | 8 | Hash index of the last address |

## Verification
Well-known group addresses, the all-ones broadcast and pseudo-random addresses are hashed. A wrong polynomial, seed, bit order or index slice shows up as an index mismatch. The same address is sent with its entry cleared, set and then cleared again, and also with its group bit clear. This separates a table lookup from a bare group test and exposes a word or bit mapping error. Gapped bytes, aborted partial addresses, stray bytes and a table write on the decision edge check that only a complete, started address yields exactly one strobe, and that the lookup sees the table before that edge.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  typedef enum logic [1:0] {
    SW_NOP  = 2'b00,
    SW_SET  = 2'b01,
    SW_CLR  = 2'b10,
    SW_WREG = 2'b11
  } sw_op_e;
endpackage

// File: rtl/mhf_crc.sv
module mhf_crc #(
  parameter int          CRC_W = 32,
  parameter int          IDX_W = 8,
  parameter logic [31:0] POLY  = 32'h04C11DB7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             init_i,
  input  logic [7:0]       byte_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [CRC_W-1:0] crc_q, crc_d;

  // shift-left register fed LSB first == bit-reversed reflected CRC
  always_comb begin
    logic [CRC_W-1:0] c;
    logic             fb;
    c = init_i ? {CRC_W{1'b1}} : crc_q;
    for (int i = 0; i < 8; i++) begin
      fb = c[CRC_W-1] ^ byte_i[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : {CRC_W{1'b0}});
    end
    crc_d = c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= {CRC_W{1'b1}};
    else if (en_i) crc_q <= crc_d;
  end

  assign idx_o = crc_q[CRC_W-1 -: IDX_W];

  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(crc_q));
endmodule

// File: rtl/mhf_addr_seq.sv
module mhf_addr_seq #(
  parameter int N_BYTES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic first_i,
  input  logic grp_bit_i,
  output logic crc_en_o,
  output logic crc_init_o,
  output logic done_o,
  output logic grp_o
);
  localparam int CNT_W = $clog2(N_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             take, done_q, grp_q;

  assign take  = valid_i && (first_i || (cnt_q != '0 && cnt_q < CNT_W'(N_BYTES)));
  assign cnt_d = first_i ? CNT_W'(1) : cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      grp_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        cnt_q <= cnt_d;
        if (first_i) grp_q <= grp_bit_i;
        if (cnt_d == CNT_W'(N_BYTES)) done_q <= 1'b1;
      end
    end
  end

  assign crc_en_o   = take;
  assign crc_init_o = first_i;
  assign done_o     = done_q;
  assign grp_o      = grp_q;

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(N_BYTES));
  a_r9_done_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cnt_q == CNT_W'(N_BYTES));
endmodule

// File: rtl/mhf_table.sv
module mhf_table
  import mhf_pkg::*;
#(
  parameter int N_REGS = 8,
  parameter int REG_W  = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  sw_op_e                            sw_op_i,
  input  logic [$clog2(N_REGS*REG_W)-1:0]   sw_idx_i,
  input  logic [REG_W-1:0]                  sw_wdata_i,
  input  logic [$clog2(N_REGS*REG_W)-1:0]   lk_idx_i,
  output logic                              lk_bit_o,
  input  logic [$clog2(N_REGS)-1:0]         rd_sel_i,
  output logic [REG_W-1:0]                  rd_data_o
);
  localparam int IDX_W = $clog2(N_REGS*REG_W);
  localparam int SEL_W = $clog2(N_REGS);
  localparam int BIT_W = $clog2(REG_W);

  logic [N_REGS-1:0][REG_W-1:0] tbl_q;
  logic [SEL_W-1:0] sw_sel, lk_sel;
  logic [BIT_W-1:0] sw_bit, lk_bit;

  assign sw_sel = sw_idx_i[IDX_W-1 -: SEL_W];
  assign sw_bit = sw_idx_i[BIT_W-1:0];
  assign lk_sel = lk_idx_i[IDX_W-1 -: SEL_W];
  assign lk_bit = lk_idx_i[BIT_W-1:0];

  // MSB-first numbering: bit b lives at REG_W-1-b == ~b
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
    end else begin
      for (int r = 0; r < N_REGS; r++) begin
        if (sw_sel == SEL_W'(r)) begin
          unique case (sw_op_i)
            SW_SET:  tbl_q[r][~sw_bit] <= 1'b1;
            SW_CLR:  tbl_q[r][~sw_bit] <= 1'b0;
            SW_WREG: tbl_q[r]          <= sw_wdata_i;
            default: ;
          endcase
        end
      end
    end
  end

  assign lk_bit_o  = tbl_q[lk_sel][~lk_bit];
  assign rd_data_o = tbl_q[rd_sel_i];

  a_r6_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_op_i == SW_SET |=> tbl_q[$past(sw_sel)][~$past(sw_bit)]);
  a_r7_clr_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_op_i == SW_CLR |=> !tbl_q[$past(sw_sel)][~$past(sw_bit)]);
  a_r8_word_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_op_i == SW_WREG |=> tbl_q[$past(sw_sel)] == $past(sw_wdata_i));
  a_r8_nop_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_op_i == SW_NOP |=> $stable(tbl_q));
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
#(
  parameter int          ADDR_BYTES = 6,
  parameter int          N_REGS     = 8,
  parameter int          REG_W      = 32,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB7,
  localparam int         IDX_W      = $clog2(N_REGS*REG_W),
  localparam int         SEL_W      = $clog2(N_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic             byte_first_i,
  input  logic [7:0]       byte_data_i,
  input  logic [1:0]       sw_op_i,
  input  logic [IDX_W-1:0] sw_idx_i,
  input  logic [REG_W-1:0] sw_wdata_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             result_valid_o,
  output logic             accept_o,
  output logic             is_group_o,
  output logic [IDX_W-1:0] hash_idx_o
);
  logic             crc_en, crc_init, done, grp, lk_bit;
  logic [IDX_W-1:0] lk_idx;
  logic             valid_q, acc_q, grp_q;
  logic [IDX_W-1:0] idx_q;

  mhf_addr_seq #(.N_BYTES(ADDR_BYTES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (byte_valid_i),
    .first_i   (byte_first_i),
    .grp_bit_i (byte_data_i[0]),
    .crc_en_o  (crc_en),
    .crc_init_o(crc_init),
    .done_o    (done),
    .grp_o     (grp)
  );

  mhf_crc #(.CRC_W(32), .IDX_W(IDX_W), .POLY(CRC_POLY)) u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (crc_en),
    .init_i(crc_init),
    .byte_i(byte_data_i),
    .idx_o (lk_idx)
  );

  mhf_table #(.N_REGS(N_REGS), .REG_W(REG_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_op_i   (sw_op_e'(sw_op_i)),
    .sw_idx_i  (sw_idx_i),
    .sw_wdata_i(sw_wdata_i),
    .lk_idx_i  (lk_idx),
    .lk_bit_o  (lk_bit),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
      grp_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= done;
      acc_q   <= done && grp && lk_bit;
      if (done) begin
        grp_q <= grp;
        idx_q <= lk_idx;
      end
    end
  end

  assign result_valid_o = valid_q;
  assign accept_o       = acc_q;
  assign is_group_o     = grp_q;
  assign hash_idx_o     = idx_q;

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);
  a_r5_accept_in_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> result_valid_o && is_group_o);
  a_r3_follows_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> result_valid_o);
endmodule

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid = 1'b0, byte_first = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [1:0]  sw_op = 2'b00;
  logic [7:0]  sw_idx = '0;
  logic [31:0] sw_wdata = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        res_valid, accept, is_group;
  logic [7:0]  hash_idx;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mcast_hash_filter uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .byte_valid_i(byte_valid), .byte_first_i(byte_first), .byte_data_i(byte_data),
    .sw_op_i(sw_op), .sw_idx_i(sw_idx), .sw_wdata_i(sw_wdata),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .result_valid_o(res_valid), .accept_o(accept),
    .is_group_o(is_group), .hash_idx_o(hash_idx)
  );

  // reflected CRC, then reversed: independent of the RTL's shift direction
  function automatic logic [7:0] ref_index(input logic [47:0] a);
    logic [31:0] c, r;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      c = c ^ {24'h0, a[47-8*k -: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    for (int j = 0; j < 32; j++) r[j] = c[31-j];
    return r[31:24];
  endfunction

  // reference model
  logic [255:0] m_tbl;
  logic [47:0]  m_buf;
  int           m_n;
  bit           m_pend, m_pgrp;
  logic [7:0]   m_pidx;
  bit           e_valid, e_acc, e_grp;
  logic [7:0]   e_idx;

  function automatic logic [31:0] model_word(input logic [2:0] s);
    logic [31:0] v;
    for (int b = 0; b < 32; b++) v[31-b] = m_tbl[s*32+b];
    return v;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tbl = '0; m_buf = '0; m_n = 0; m_pend = 0; m_pgrp = 0; m_pidx = '0;
      e_valid = 0; e_acc = 0; e_grp = 0; e_idx = '0;
    end else begin
      bit took;
      e_valid = 0; e_acc = 0;
      if (m_pend) begin
        e_valid = 1; e_idx = m_pidx; e_grp = m_pgrp;
        e_acc = m_pgrp && m_tbl[m_pidx];
        m_pend = 0;
      end
      case (sw_op)
        2'b01: m_tbl[sw_idx] = 1'b1;
        2'b10: m_tbl[sw_idx] = 1'b0;
        2'b11: for (int b = 0; b < 32; b++) m_tbl[sw_idx[7:5]*32+b] = sw_wdata[31-b];
        default: ;
      endcase
      took = 0;
      if (byte_valid) begin
        if (byte_first) begin
          m_buf = {40'h0, byte_data}; m_n = 1; took = 1;
        end else if (m_n > 0 && m_n < 6) begin
          m_buf = {m_buf[39:0], byte_data}; m_n++; took = 1;
        end
      end
      if (took && m_n == 6) begin
        m_pend = 1; m_pidx = ref_index(m_buf); m_pgrp = m_buf[40];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, 5 ns after the active edge
  always begin
    @(posedge clk); #5;
    if (rst_ni && !finished) begin
      chk("R3 R9 result_valid", {31'h0, res_valid}, {31'h0, e_valid});
      chk("R5 R10 accept", {31'h0, accept}, {31'h0, e_acc});
      if (e_valid) begin
        chk("R2 hash_idx", {24'h0, hash_idx}, {24'h0, e_idx});
        chk("R5 is_group", {31'h0, is_group}, {31'h0, e_grp});
      end
      chk("R1 R4 R6 R7 R8 rd_data", rd_data, model_word(rd_sel));
    end
  end

  task automatic drive(input logic v, input logic f, input logic [7:0] d,
                       input logic [1:0] op, input logic [7:0] ix, input logic [31:0] wd);
    @(negedge clk);
    byte_valid = v; byte_first = f; byte_data = d;
    sw_op = op; sw_idx = ix; sw_wdata = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 8'h00, 2'b00, 8'h00, 32'h0);
  endtask

  task automatic sw(input logic [1:0] op, input logic [7:0] ix, input logic [31:0] wd);
    drive(0, 0, 8'h00, op, ix, wd);
  endtask

  task automatic send_addr(input logic [47:0] a, input int gap);
    for (int k = 0; k < 6; k++) begin
      drive(1, k == 0, a[47-8*k -: 8], 2'b00, 8'h00, 32'h0);
      if (k < 5) idle(gap);
    end
  endtask

  localparam logic [47:0] A_V4  = 48'h01005E000001;
  localparam logic [47:0] A_V6  = 48'h333300000001;
  localparam logic [47:0] A_BC  = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] A_STP = 48'h0180C2000000;
  localparam logic [47:0] A_UNI = 48'h001122334455;

  initial begin
    logic [31:0] lcg;
    lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state visible on every word
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #1 chk("R1 reset word", rd_data, 32'h0);
      chk("R1 reset strobe", {30'h0, res_valid, accept}, 32'h0);
      @(negedge clk);
    end
    // R9: stray bytes before any start are ignored
    drive(1, 0, 8'h01, 2'b00, 8'h00, 32'h0);
    drive(1, 0, 8'h02, 2'b00, 8'h00, 32'h0);
    idle(3);
    // empty table rejects
    send_addr(A_V4, 0); idle(3);
    // R6: set entry, then accept
    rd_sel = ref_index(A_V4) >> 5;
    sw(2'b01, ref_index(A_V4), 32'h0);
    send_addr(A_V4, 0); idle(3);
    // R5: unicast with its entry set is still rejected
    sw(2'b01, ref_index(A_UNI), 32'h0);
    send_addr(A_UNI, 1); idle(3);
    // R7: clear only the one entry
    sw(2'b10, ref_index(A_V4), 32'h0);
    send_addr(A_V4, 0); idle(3);
    // R8: whole-word writes
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      sw(2'b11, 8'(s << 5), 32'hFFFF_FFFF);
    end
    send_addr(A_BC, 0); idle(2);
    send_addr(A_V6, 2); idle(2);
    send_addr(A_UNI, 0); idle(2);
    rd_sel = 3'd3;
    sw(2'b11, 8'h60, 32'hA5A5_0F0F);
    sw(2'b01, 8'h61, 32'h0);
    sw(2'b10, 8'h7F, 32'h0);
    idle(1);
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      sw(2'b11, 8'(s << 5), 32'h0);
    end
    // R9: aborted partial address, then a full one
    rd_sel = ref_index(A_STP) >> 5;
    sw(2'b01, ref_index(A_STP), 32'h0);
    drive(1, 1, 8'h01, 2'b00, 8'h00, 32'h0);
    drive(1, 0, 8'h22, 2'b00, 8'h00, 32'h0);
    drive(1, 0, 8'h33, 2'b00, 8'h00, 32'h0);
    send_addr(A_STP, 0);
    // R9: bytes after the sixth are ignored
    drive(1, 0, 8'hAA, 2'b00, 8'h00, 32'h0);
    drive(1, 0, 8'hBB, 2'b00, 8'h00, 32'h0);
    drive(1, 0, 8'hCC, 2'b00, 8'h00, 32'h0);
    idle(3);
    // R10: clear on the decision edge must not affect this result
    send_addr(A_STP, 0);
    sw(2'b10, ref_index(A_STP), 32'h0);
    idle(2);
    send_addr(A_STP, 0);
    sw(2'b01, ref_index(A_STP), 32'h0);
    idle(2);
    // back-to-back addresses and pseudo-random traffic
    send_addr(A_V6, 0);
    send_addr(A_V4, 0);
    for (int i = 0; i < 60; i++) begin
      logic [47:0] a;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a[47:24] = lcg[31:8];
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a[23:0] = lcg[31:8];
      rd_sel = lcg[2:0];
      case (lcg[5:4])
        2'd0: sw(2'b01, ref_index(a), 32'h0);
        2'd1: sw(2'b10, ref_index(a), 32'h0);
        2'd2: sw(2'b11, lcg[15:8], lcg ^ 32'h5A5A_3C3C);
        default: ;
      endcase
      send_addr(a, int'(lcg[7:6]) % 2);
      if (lcg[3]) sw(2'b01, lcg[23:16], 32'h0);
      idle(int'(lcg[9:8]));
    end
    idle(4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule